// File: doc/BRIEF.md
# Fast Serial Port Transceiver

This block is an asynchronous serial transmitter and receiver driven from a small register port. A programmable divisor sets the bit rate; one bit time is sixteen ticks of an oversampling clock enable derived from it. Transmission goes through a one-byte holding stage in front of a shift engine. The engine can append one or two stop bits. It can also be held back by a clear-to-send level of selectable polarity, or paused by an XOFF character seen on the receive line.

Received bytes are checked at the middle of each bit and stored in a small FIFO that software drains through the data register. A bad stop bit raises a framing flag. A byte that arrives while the FIFO is full is dropped and raises an overflow flag. In block mode the transmitter pulls bytes from a valid/ready byte stream instead of the data register. It inserts a programmable idle gap between bytes and stops after a programmed number of 16-bit words.

Top module: `fast_serial_port`

## Requirements
- R1: After reset the txd line is high, STATUS bit0 (receive ready) is 0, STATUS bit1 (transmit ready) is 1, CTRL reads 0 and the block counter (address 5) reads 0x3FF.
- R2: A transmitted frame is one low start bit, eight data bits least significant first, then high stop bits. CTRL bit1 = 1 gives one stop bit, so back-to-back frames start 10 bit times apart. CTRL bit1 = 0 gives two stop bits and a spacing of 11 bit times.
- R3: One bit time lasts 16 x (BAUD + 1) clock cycles, where BAUD is register address 2. This holds for transmit and receive.
- R4: A received byte with a high stop bit enters the receive FIFO. STATUS bit0 is 1 while the FIFO holds a byte. Each read of DATA (address 3) returns the oldest byte and removes it.
- R5: The FIFO holds 8 bytes. A byte received while it is full is dropped and sets STATUS bit2. That flag stays set until 1 is written to STATUS bit2.
- R6: A received frame whose first stop bit samples low is discarded and sets STATUS bit3. Writing 1 to STATUS bit3 clears the flag.
- R7: The receiver accepts frames that follow each other directly with either one or two stop bits.
- R8: With CTRL bit2 = 1, no frame starts unless the synchronised cts input equals CTRL bit3. A waiting byte is held and STATUS bit1 stays 0.
- R9: In block mode, the start of one frame follows the start of the previous frame by the frame length plus (GAP - 9) bit times, where GAP is register address 4. A GAP of 9 or less adds no idle time.
- R10: The block counter holds the number of words minus one. Writing CTRL bit5 = 1 starts a block, and the block takes exactly 2 x (count + 1) bytes from the stream. The block then ends: strm_ready falls, STATUS bit5 clears and the counter reads 0x3FF.
- R11: With CTRL bit4 = 1, a received 0x13 sets STATUS bit4 and prevents new frames from starting. A received 0x11 clears STATUS bit4 and releases them. Neither character is stored in the FIFO.
- R12: STATUS bit1 rises within two cycles of a DATA write that is accepted while the engine is idle. It is already high while that frame is still being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO on DATA) |
| reg_addr | input | 3 | Register address: 0 CTRL, 1 STATUS, 2 BAUD, 3 DATA, 4 GAP, 5 block counter |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| cts | input | 1 | Clear-to-send level |
| strm_data | input | 8 | Block-mode byte from the stream |
| strm_valid | input | 1 | Stream byte valid |
| strm_ready | output | 1 | Stream byte taken on this clock edge when valid |

## Verification
Two events can land on the same clock edge: the stream handshake that hands over the final byte of a block, and the block counter wrapping from 0 to 0x3FF while the block-busy flag clears. A two-word block brings them together. The bench then checks that exactly four bytes were taken and sent with the expected start spacing. It also checks that strm_ready drops at once and that the counter and the STATUS busy bit read back as finished. A second block with a single word and a short gap checks the same edge with no idle time inserted.

// File: rtl/fsp_pkg.sv
// Shared constants and types for the fast serial port.
package fsp_pkg;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_BAUD = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_GAP  = 3'd4;
    localparam logic [2:0] A_BCNT = 3'd5;
    localparam logic [7:0] XOFF_CHAR = 8'h13;
    localparam logic [7:0] XON_CHAR  = 8'h11;
    localparam int GAP_OFFSET = 9;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/fsp_tick_gen.sv
// Oversampling tick generator: one-cycle pulse every (div+1) clocks while run.
// Assumes div is stable during use; counter restarts when run is low.
module fsp_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count clocks and emit a registered tick at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == div);
            cnt  <= (cnt == div) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsp_tx_engine.sv
// Transmit shift engine: sends start, 8 data bits LSB first, 1 or 2 stop bits,
// then gap_bits idle bit times, all counted in 16-tick bit cells.
// Assumes load is only honoured while idle; stop count and gap latch at load.
module fsp_tx_engine #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [7:0]       din,
    input  logic             two_stop,
    input  logic [GAP_W-1:0] gap_bits,
    output logic             busy,
    output logic             txd
);
    localparam int LW = GAP_W + 2;

    logic [LW-1:0] bits_left;
    logic [3:0]    tcnt;
    logic [9:0]    shreg;

    // Load a frame, then shift one bit out per sixteen ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_left <= '0;
            tcnt      <= '0;
            shreg     <= '1;
        end else if (load && !busy) begin
            shreg     <= {1'b1, din, 1'b0};
            bits_left <= LW'(10) + LW'(two_stop) + LW'(gap_bits);
            tcnt      <= '0;
        end else if (busy && tick) begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'hF) begin
                shreg     <= {1'b1, shreg[9:1]};
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    assign busy = (bits_left != '0);
    assign txd  = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/fsp_rx_engine.sv
// Receive engine with 16x oversampling: confirms the start bit at mid-bit,
// samples data at bit centres, checks the first stop bit only.
// Assumes rxd is asynchronous; it is synchronised here.
module fsp_rx_engine
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] dout,
    output logic       frame_err
);
    logic      rx_meta, rx_s;
    rx_state_e state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] shreg;

    // Two-flop synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_s    <= rx_meta;
        end
    end

    // Frame state machine advanced on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            push      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            push      <= 1'b0;
            frame_err <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            tcnt  <= '0;
                            state <= RX_START;
                        end
                    end
                    RX_START: begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == 4'd7) begin
                            tcnt  <= '0;
                            bidx  <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == 4'hF) begin
                            shreg <= {rx_s, shreg[7:1]};
                            bidx  <= bidx + 3'd1;
                            if (bidx == 3'd7) state <= RX_STOP;
                        end
                    end
                    default: begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == 4'hF) begin
                            push      <= rx_s;
                            frame_err <= !rx_s;
                            state     <= RX_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    assign dout = shreg;
endmodule

// File: rtl/fsp_rx_fifo.sv
// Receive byte FIFO: drops pushes when full and reports them as ovf_evt.
// Assumes pop is only meaningful when count is nonzero.
module fsp_rx_fifo #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [7:0]                 din,
    input  logic                       pop,
    output logic [7:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign ovf_evt = push && full;
    assign dout    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/fast_serial_port.sv
// Fast serial port top: register file, transmit holding stage with flow
// control and block streaming, receive dispatch into the FIFO.
// Assumes a single register master; reads have no side effect except DATA.
module fast_serial_port
    import fsp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int GAP_W      = 8,
    parameter int CNT_W      = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        txd,
    input  logic        rxd,
    input  logic        cts,
    input  logic [7:0]  strm_data,
    input  logic        strm_valid,
    output logic        strm_ready
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic en, one_stop, cts_en, cts_pol, xoff_en;
    logic [DIV_W-1:0] div;
    logic [GAP_W-1:0] gap;
    logic [CNT_W-1:0] blkcnt;
    logic blk_busy, byte_phase;
    logic hold_valid;
    logic [7:0] hold_byte;
    logic paused, ovf_flag, ferr_flag;
    logic cts_meta, cts_s, cts_ok;
    logic tick, eng_busy, tx_load;
    logic [GAP_W-1:0] gap_bits;
    logic rx_push, rx_ferr, is_flow_char, fifo_push, fifo_pop, ovf_evt;
    logic [7:0] rx_byte, fifo_dout;
    logic [CW-1:0] fifo_cnt;
    logic wr_ctrl, wr_stat, wr_data, wr_bcnt, strm_take, tx_ready;
    logic ovf_clr, blkcnt_wr;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == A_STAT);
    assign wr_data   = reg_wr && (reg_addr == A_DATA);
    assign wr_bcnt   = reg_wr && (reg_addr == A_BCNT);
    assign tx_ready  = !hold_valid && !blk_busy;
    assign strm_ready = blk_busy && !hold_valid;
    assign strm_take = strm_ready && strm_valid;
    assign blkcnt_wr = wr_bcnt && !blk_busy;
    assign ovf_clr   = wr_stat && reg_wdata[2];

    // Synchronise the clear-to-send input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_meta <= 1'b0;
            cts_s    <= 1'b0;
        end else begin
            cts_meta <= cts;
            cts_s    <= cts_meta;
        end
    end

    assign cts_ok   = !cts_en || (cts_s == cts_pol);
    assign tx_load  = en && hold_valid && !eng_busy && cts_ok && !paused;
    assign gap_bits = (blk_busy && gap > GAP_W'(GAP_OFFSET)) ? gap - GAP_W'(GAP_OFFSET) : '0;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            one_stop <= 1'b0;
            cts_en   <= 1'b0;
            cts_pol  <= 1'b0;
            xoff_en  <= 1'b0;
            div      <= '0;
            gap      <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                en       <= reg_wdata[0];
                one_stop <= reg_wdata[1];
                cts_en   <= reg_wdata[2];
                cts_pol  <= reg_wdata[3];
                xoff_en  <= reg_wdata[4];
            end
            if (reg_addr == A_BAUD) div <= reg_wdata[DIV_W-1:0];
            if (reg_addr == A_GAP)  gap <= reg_wdata[GAP_W-1:0];
        end
    end

    // Holding stage, block sequencing and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_byte  <= '0;
            blk_busy   <= 1'b0;
            byte_phase <= 1'b0;
            blkcnt     <= '1;
        end else begin
            if (tx_load) hold_valid <= 1'b0;
            if (wr_data && tx_ready) begin
                hold_valid <= 1'b1;
                hold_byte  <= reg_wdata[7:0];
            end
            if (blkcnt_wr) blkcnt <= reg_wdata[CNT_W-1:0];
            if (wr_ctrl && reg_wdata[5] && !blk_busy) begin
                blk_busy   <= 1'b1;
                byte_phase <= 1'b0;
            end
            if (strm_take) begin
                hold_valid <= 1'b1;
                hold_byte  <= strm_data;
                byte_phase <= !byte_phase;
                if (byte_phase) begin
                    blkcnt <= blkcnt - 1'b1;
                    if (blkcnt == '0) blk_busy <= 1'b0;
                end
            end
        end
    end

    assign is_flow_char = xoff_en && (rx_byte == XOFF_CHAR || rx_byte == XON_CHAR);
    assign fifo_push    = rx_push && !is_flow_char;
    assign fifo_pop     = reg_rd && (reg_addr == A_DATA);

    // Receive-side flags: pause state, overflow and framing errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused    <= 1'b0;
            ovf_flag  <= 1'b0;
            ferr_flag <= 1'b0;
        end else begin
            if (!xoff_en)                    paused <= 1'b0;
            else if (rx_push && is_flow_char) paused <= (rx_byte == XOFF_CHAR);
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
            if (rx_ferr)                           ferr_flag <= 1'b1;
            else if (wr_stat && reg_wdata[3])      ferr_flag <= 1'b0;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {10'd0, blk_busy, xoff_en, cts_pol, cts_en, one_stop, en};
            A_STAT:  reg_rdata = {10'd0, blk_busy, paused, ferr_flag, ovf_flag, tx_ready,
                                  (fifo_cnt != '0)};
            A_BAUD:  reg_rdata = 16'(div);
            A_DATA:  reg_rdata = {8'd0, fifo_dout};
            A_GAP:   reg_rdata = 16'(gap);
            A_BCNT:  reg_rdata = 16'(blkcnt);
            default: reg_rdata = '0;
        endcase
    end

    fsp_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(en), .div(div), .tick(tick)
    );

    fsp_tx_engine #(.GAP_W(GAP_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .din(hold_byte),
        .two_stop(!one_stop), .gap_bits(gap_bits), .busy(eng_busy), .txd(txd)
    );

    fsp_rx_engine u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .push(rx_push), .dout(rx_byte), .frame_err(rx_ferr)
    );

    fsp_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(rx_byte), .pop(fifo_pop),
        .dout(fifo_dout), .count(fifo_cnt), .ovf_evt(ovf_evt)
    );
endmodule

// File: rtl/fsp_checker.sv
// Property checker for the fast serial port, attached with bind.
module fsp_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 10,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             eng_busy,
    input logic             cts_ok,
    input logic             paused,
    input logic [CW-1:0]    fifo_cnt,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic             blk_busy,
    input logic             blkcnt_wr,
    input logic [CNT_W-1:0] blkcnt
);
    // R2: line idles high whenever the engine is not sending
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> txd);

    // R8 and R11: a new frame only begins when flow control permits
    p_start_permitted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(cts_ok && !paused));

    // R5: occupancy never exceeds capacity
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R5: overflow flag is sticky until cleared
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    // R10: counter only moves during a block or on a write
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_busy && !blkcnt_wr |=> $stable(blkcnt));
endmodule

bind fast_serial_port fsp_checker #(
    .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .CW($clog2(FIFO_DEPTH + 1))
) u_fsp_checker (
    .clk(clk), .rst_n(rst_n), .txd(txd), .eng_busy(eng_busy), .cts_ok(cts_ok),
    .paused(paused), .fifo_cnt(fifo_cnt), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .blk_busy(blk_busy), .blkcnt_wr(blkcnt_wr), .blkcnt(blkcnt)
);

// File: tb/fast_serial_port_bench.sv
module fast_serial_port_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, reg_wr, reg_rd, rxd, cts, strm_valid, strm_ready, txd;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [7:0]  strm_data;

    fast_serial_port u_fast_serial_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd), .rxd(rxd), .cts(cts),
        .strm_data(strm_data), .strm_valid(strm_valid), .strm_ready(strm_ready)
    );

    int total = 0, bad = 0, cyc = 0, bitclk = 32;
    logic [7:0] exp_q[$];
    int starts[$];
    logic [15:0] rv;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input int nstop, input bit bad_stop);
        rxd = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitclk) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (bitclk * 5 / 8) @(negedge clk);
            rxd = 1'b1;
            repeat (bitclk) @(negedge clk);
        end else begin
            rxd = 1'b1;
            repeat (bitclk * nstop) @(negedge clk);
        end
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        wr(3'd3, {8'd0, b});
    endtask

    task automatic wait_tx_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (bitclk * 3) @(negedge clk);
    endtask

    task automatic check_gap(input int idx, input int bits, input string tag);
        int d;
        d = starts[idx + 1] - starts[idx];
        check(d >= bits * bitclk - 4 && d <= bits * bitclk + 4, tag, d, bits * bitclk);
    endtask

    task automatic stream(input logic [7:0] b);
        exp_q.push_back(b);
        strm_data = b; strm_valid = 1'b1;
        while (!strm_ready) @(negedge clk);
        @(negedge clk);
        strm_valid = 1'b0;
    endtask

    // Monitor: decodes frames on txd and compares against the scoreboard queue.
    initial begin : monitor
        logic [7:0] b;
        logic prv;
        prv = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && prv === 1'b1 && txd === 1'b0) begin
                starts.push_back(cyc);
                repeat (bitclk / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (bitclk) @(negedge clk);
                    b[i] = txd;
                end
                repeat (bitclk) @(negedge clk);
                check(txd === 1'b1, "R2 stop bit high", txd, 1);
                if (exp_q.size() == 0) check(1'b0, "R2 unexpected frame", b, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(b == e, "R2 frame data", b, e);
                end
            end
            prv = txd;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        summary();
        $finish;
    end

    initial begin
        int n0;
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        rxd = 1'b1; cts = 1'b0; strm_valid = 0; strm_data = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(txd === 1'b1, "R1 txd idle", txd, 1);
        rd(3'd1, rv); check(rv[1:0] == 2'b10, "R1 status ready bits", rv[1:0], 2);
        rd(3'd0, rv); check(rv == 16'd0, "R1 ctrl", rv, 0);
        rd(3'd5, rv); check(rv == 16'h3FF, "R1 R10 counter reset", rv, 16'h3FF);

        // R2 R3 R12 one stop bit, back-to-back
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h3);
        n0 = starts.size();
        send_tx(8'hA5);
        repeat (2) @(negedge clk);
        rd(3'd1, rv);
        check(rv[1] == 1'b1 && txd == 1'b0, "R12 ready during frame", {rv[1], txd}, 2);
        send_tx(8'h3C);
        wait_tx_idle();
        check_gap(n0, 10, "R2 R3 one stop spacing");

        // R2 two stop bits
        wr(3'd0, 16'h1);
        n0 = starts.size();
        send_tx(8'h5E);
        repeat (3) @(negedge clk);
        send_tx(8'h81);
        wait_tx_idle();
        check_gap(n0, 11, "R2 two stop spacing");
        wr(3'd0, 16'h3);

        // R4 R7 receive with one and two stop bits
        send_rx(8'h5A, 1, 0);
        send_rx(8'hC3, 2, 0);
        send_rx(8'h81, 1, 0);
        repeat (4) @(negedge clk);
        rd(3'd1, rv); check(rv[0] == 1'b1, "R4 rx ready", rv[0], 1);
        rd(3'd3, rv); check(rv[7:0] == 8'h5A, "R4 R7 rx byte 1", rv[7:0], 8'h5A);
        rd(3'd3, rv); check(rv[7:0] == 8'hC3, "R7 rx byte after two stops", rv[7:0], 8'hC3);
        rd(3'd3, rv); check(rv[7:0] == 8'h81, "R7 rx byte 3", rv[7:0], 8'h81);
        rd(3'd1, rv); check(rv[0] == 1'b0, "R4 rx ready clears", rv[0], 0);

        // R6 framing error
        send_rx(8'h55, 1, 1);
        repeat (4) @(negedge clk);
        rd(3'd1, rv); check(rv[3:0] == 4'b1010, "R6 ferr set byte dropped", rv[3:0], 4'b1010);
        wr(3'd1, 16'h8);
        rd(3'd1, rv); check(rv[3] == 1'b0, "R6 ferr cleared", rv[3], 0);

        // R5 overflow
        for (int i = 0; i < 9; i++) send_rx(8'(8'h20 + i), 1, 0);
        repeat (4) @(negedge clk);
        rd(3'd1, rv); check(rv[2] == 1'b1, "R5 overflow flag", rv[2], 1);
        for (int i = 0; i < 8; i++) begin
            rd(3'd3, rv);
            check(rv[7:0] == 8'(8'h20 + i), "R5 fifo order", rv[7:0], 8'h20 + i);
        end
        rd(3'd1, rv); check(rv[0] == 1'b0 && rv[2] == 1'b1, "R5 ninth dropped", rv[2:0], 3'b110);
        wr(3'd1, 16'h4);
        rd(3'd1, rv); check(rv[2] == 1'b0, "R5 overflow cleared", rv[2], 0);

        // R8 clear-to-send, active-high then active-low
        wr(3'd0, 16'hF);
        cts = 1'b0;
        n0 = starts.size();
        send_tx(8'h77);
        repeat (200) @(negedge clk);
        check(starts.size() == n0, "R8 blocked by cts", starts.size() - n0, 0);
        rd(3'd1, rv); check(rv[1] == 1'b0, "R8 tx ready low while held", rv[1], 0);
        cts = 1'b1;
        wait_tx_idle();
        check(starts.size() == n0 + 1, "R8 released by cts", starts.size() - n0, 1);
        wr(3'd0, 16'h7);
        cts = 1'b0;
        send_tx(8'h78);
        wait_tx_idle();
        check(starts.size() == n0 + 2, "R8 low polarity sends", starts.size() - n0, 2);

        // R11 XOFF / XON
        wr(3'd0, 16'h13);
        send_rx(8'h13, 1, 0);
        repeat (4) @(negedge clk);
        rd(3'd1, rv); check(rv[4] == 1'b1 && rv[0] == 1'b0, "R11 paused, xoff not stored", rv[4:0], 5'h12);
        n0 = starts.size();
        send_tx(8'h42);
        repeat (200) @(negedge clk);
        check(starts.size() == n0, "R11 no start while paused", starts.size() - n0, 0);
        send_rx(8'h11, 1, 0);
        wait_tx_idle();
        check(starts.size() == n0 + 1, "R11 resumed", starts.size() - n0, 1);
        rd(3'd1, rv); check(rv[4] == 1'b0 && rv[0] == 1'b0, "R11 unpaused, xon not stored", rv[4:0], 5'h02);

        // R9 R10 block mode, two words, gap 12
        wr(3'd0, 16'h3);
        wr(3'd4, 16'd12);
        wr(3'd5, 16'd1);
        n0 = starts.size();
        wr(3'd0, 16'h23);
        stream(8'hA1); stream(8'hB2); stream(8'hC3); stream(8'hD4);
        repeat (2) @(negedge clk);
        check(strm_ready == 1'b0, "R10 stream stops after count", strm_ready, 0);
        rd(3'd1, rv); check(rv[5] == 1'b0, "R10 block busy clears", rv[5], 0);
        rd(3'd5, rv); check(rv == 16'h3FF, "R10 counter reads 0x3FF", rv, 16'h3FF);
        wait_tx_idle();
        check(starts.size() == n0 + 4, "R10 four bytes sent", starts.size() - n0, 4);
        for (int i = 0; i < 3; i++) check_gap(n0 + i, 13, "R9 block gap spacing");

        // R9 R10 single word, gap below offset
        wr(3'd4, 16'd5);
        wr(3'd5, 16'd0);
        n0 = starts.size();
        wr(3'd0, 16'h23);
        stream(8'h3A); stream(8'h4B);
        wait_tx_idle();
        check(starts.size() == n0 + 2, "R10 one word two bytes", starts.size() - n0, 2);
        check_gap(n0, 10, "R9 no idle for small gap");

        // R3 other divisor
        wr(3'd2, 16'd2);
        bitclk = 48;
        n0 = starts.size();
        send_tx(8'h96);
        repeat (3) @(negedge clk);
        send_tx(8'h69);
        wait_tx_idle();
        check_gap(n0, 10, "R3 divisor 2 spacing");
        send_rx(8'h6E, 1, 0);
        repeat (4) @(negedge clk);
        rd(3'd3, rv); check(rv[7:0] == 8'h6E, "R3 rx at divisor 2", rv[7:0], 8'h6E);

        check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule